// File: doc/BRIEF.md
# Receive Byte Assembler with Valid Strobe

This block sits behind a serial receive path that has already decoded the line and removed stuffed bits. It paces itself on an interface clock that runs a fixed number of times faster than the bit rate. Once per bit slot it samples a data bit, together with a flag marking the slot as a removed stuffed bit. It shifts the data bits into a hold register, least significant bit first. When a byte completes, a small controller moves to an output state for one clock. In that clock a registered valid strobe accompanies the byte on the parallel bus. The controller then returns to waiting while the next byte gathers.

A stuffed slot carries no data, so each one pushes the next byte's strobe one bit time later. The block keeps a count of stuffed slots across the packet, whether or not they sit next to each other. When that count wraps, the byte being gathered is given up and the strobe for it is skipped. The packet-active input frames all activity: dropping it clears all partial state. An error input stops any further strobes until the packet ends.

Top module: `rx_byte_gather`

## Requirements
- R1: While `rst` is high and after it is released, `rx_valid` is 0 and `rx_data` is 0 until the first byte is produced.
- R2: Data bits enter least significant bit first: the first data slot of a byte ends up in `rx_data[0]` and the eighth in `rx_data[7]`.
- R3: For each completed byte, `rx_valid` is high for exactly one clock. That clock is the one right after the clock edge that samples the byte's last data bit. `rx_data` holds that byte during the strobe and changes at no other time.
- R4: Bit slots are sampled every `CLKS_PER_BIT` clocks, starting at the rising of `pkt_active`. The first slot is sampled on the `CLKS_PER_BIT`-th rising edge with `pkt_active` high. Without stuffing, consecutive strobes are `8*CLKS_PER_BIT` clocks apart (40 at the default of 5).
- R5: A slot sampled with `ser_stuffed` = 1 adds no data bit and delays the current byte's strobe by `CLKS_PER_BIT` clocks: one stuffed slot gives 45 clocks, two give 50 at the default.
- R6: Stuffed slots are counted over the whole packet, adjacent or not. The eighth one wraps the count to zero, and the byte being gathered at that point produces no strobe. The following byte is handled normally.
- R7: When `pkt_active` is low, the partial byte, the bit count and the stuffed-slot count are cleared, and no strobe appears in the next clock. The next packet starts a fresh byte with a stuffed-slot count of zero.
- R8: Once `ser_err` is seen high while `pkt_active` is high, no strobe appears until `pkt_active` has gone low. The next packet works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_active | input | 1 | High for the duration of a received packet |
| ser_bit | input | 1 | Unstuffed data bit for the current slot |
| ser_stuffed | input | 1 | 1 when the current slot was a removed stuffed bit |
| ser_err | input | 1 | Error indication from the unstuffer |
| rx_data | output | BYTE_W | Assembled byte, valid with the strobe |
| rx_valid | output | 1 | One-clock strobe per delivered byte |

## Verification
On every clock the assertions check four things. The strobe is never longer than one clock. The byte bus moves only together with the strobe. Two strobes within one packet are never closer than one nominal byte time. The strobe stays silent after an error and in the clock after the packet ends. The exact clock in which each strobe lands, the bit order inside the byte, and the stretch from each stuffed slot can only be shown by the bench scenarios. The same holds for the skipped byte at the stuffed-count wrap and for the clearing of state between packets.

// File: rtl/rxa_pkg.sv
`timescale 1ns/1ps
package rxa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OUT  = 2'd2,
    ST_HALT = 2'd3
  } rxa_state_t;
endpackage

// File: rtl/rxa_slot_timer.sv
`timescale 1ns/1ps
module rxa_slot_timer #(
  parameter int CLKS_PER_BIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_BIT - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign tick = run && (phase == LAST);
endmodule

// File: rtl/rxa_shifter.sv
`timescale 1ns/1ps
module rxa_shifter #(
  parameter int BYTE_W     = 8,
  parameter int STUFF_WRAP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic              ser_bit,
  input  logic              ser_stuffed,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              byte_drop
);
  localparam int BCW = $clog2(BYTE_W);
  localparam int SCW = $clog2(STUFF_WRAP);
  localparam logic [BCW-1:0] BIT_LAST   = BCW'(BYTE_W - 1);
  localparam logic [SCW-1:0] STUFF_LAST = SCW'(STUFF_WRAP - 1);

  logic [BYTE_W-1:0] hold;
  logic [BCW-1:0]    bit_cnt;
  logic [SCW-1:0]    stuff_cnt;
  logic              drop;
  logic              data_slot;
  logic              stuff_slot;

  assign data_slot  = tick && !ser_stuffed;
  assign stuff_slot = tick && ser_stuffed;
  assign byte_done  = data_slot && (bit_cnt == BIT_LAST);
  assign byte_val   = {ser_bit, hold[BYTE_W-1:1]};
  assign byte_drop  = drop;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hold      <= '0;
      bit_cnt   <= '0;
      stuff_cnt <= '0;
      drop      <= 1'b0;
    end else begin
      if (stuff_slot) begin
        if (stuff_cnt == STUFF_LAST) begin
          stuff_cnt <= '0;
          drop      <= 1'b1;
        end else begin
          stuff_cnt <= stuff_cnt + 1'b1;
        end
      end
      if (data_slot) begin
        hold <= byte_val;
        if (byte_done) begin
          bit_cnt <= '0;
          drop    <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxa_ctrl.sv
`timescale 1ns/1ps
module rxa_ctrl
  import rxa_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_active,
  input  logic              err,
  input  logic              byte_done,
  input  logic              byte_drop,
  input  logic [BYTE_W-1:0] byte_val,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);
  rxa_state_t state;
  logic       waiting;
  logic       load;

  assign waiting = (state == ST_IDLE) || (state == ST_WAIT);
  assign load    = pkt_active && !err && waiting && byte_done && !byte_drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else if (!pkt_active) begin
      state <= ST_IDLE;
    end else if (err) begin
      state <= ST_HALT;
    end else begin
      case (state)
        ST_IDLE, ST_WAIT: state <= load ? ST_OUT : ST_WAIT;
        ST_OUT:           state <= ST_WAIT;
        default:          state <= ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
    end else if (load) begin
      rx_data <= byte_val;
    end
  end

  assign rx_valid = (state == ST_OUT);
endmodule

// File: rtl/rx_byte_gather.sv
`timescale 1ns/1ps
module rx_byte_gather #(
  parameter int CLKS_PER_BIT = 5,
  parameter int BYTE_W       = 8,
  parameter int STUFF_WRAP   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_active,
  input  logic              ser_bit,
  input  logic              ser_stuffed,
  input  logic              ser_err,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);
  logic              tick;
  logic              byte_done;
  logic              byte_drop;
  logic [BYTE_W-1:0] byte_val;

  rxa_slot_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) i_timer (
    .clk (clk),
    .rst (rst),
    .run (pkt_active),
    .tick(tick)
  );

  rxa_shifter #(
    .BYTE_W    (BYTE_W),
    .STUFF_WRAP(STUFF_WRAP)
  ) i_shift (
    .clk        (clk),
    .rst        (rst),
    .clr        (!pkt_active),
    .tick       (tick),
    .ser_bit    (ser_bit),
    .ser_stuffed(ser_stuffed),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .byte_drop  (byte_drop)
  );

  rxa_ctrl #(
    .BYTE_W(BYTE_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pkt_active(pkt_active),
    .err       (ser_err),
    .byte_done (byte_done),
    .byte_drop (byte_drop),
    .byte_val  (byte_val),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );
endmodule

// File: rtl/rx_byte_gather_chk.sv
`timescale 1ns/1ps
module rx_byte_gather_chk #(
  parameter int CLKS_PER_BIT = 5,
  parameter int BYTE_W       = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pkt_active,
  input logic              ser_err,
  input logic [BYTE_W-1:0] rx_data,
  input logic              rx_valid
);
  localparam logic [15:0] GAP = 16'(BYTE_W * CLKS_PER_BIT);

  logic        err_seen;
  logic        seen;
  logic [15:0] since;

  always_ff @(posedge clk) begin
    if (rst || !pkt_active) begin
      err_seen <= 1'b0;
      seen     <= 1'b0;
      since    <= '0;
    end else begin
      if (ser_err) err_seen <= 1'b1;
      if (rx_valid) begin
        seen  <= 1'b1;
        since <= 16'd1;
      end else if (since != 16'hFFFF) begin
        since <= since + 16'd1;
      end
    end
  end

  // R3: one clock wide
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R3: bus moves only with the strobe
  a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_data != $past(rx_data)) |-> rx_valid);

  // R4: strobes within a packet at least one nominal byte time apart
  a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && seen) |-> (since >= GAP));

  // R7: silent after packet end
  a_r7_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !pkt_active |=> !rx_valid);

  // R8: silent after error
  a_r8_halt_silent: assert property (@(posedge clk) disable iff (rst)
    err_seen |-> !rx_valid);
endmodule

bind rx_byte_gather rx_byte_gather_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .BYTE_W      (BYTE_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .pkt_active(pkt_active),
  .ser_err   (ser_err),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid)
);

// File: tb/test_rx_byte_gather.sv
`timescale 1ns/1ps
module test_rx_byte_gather;
  localparam int CPB  = 5;
  localparam int W    = 8;
  localparam int WRAP = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pkt_active = 1'b0;
  logic         ser_bit = 1'b0;
  logic         ser_stuffed = 1'b0;
  logic         ser_err = 1'b0;
  logic [W-1:0] rx_data;
  logic         rx_valid;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int           m_bits = 0;
  int           m_stuff = 0;
  bit           m_drop = 0;
  bit           m_halt = 0;
  logic [W-1:0] m_hold = '0;
  logic [W-1:0] m_last = '0;
  int           n_strobe = 0;
  int           t_prev = 0;
  int           t_cur = 0;

  rx_byte_gather #(
    .CLKS_PER_BIT(CPB),
    .BYTE_W      (W),
    .STUFF_WRAP  (WRAP)
  ) i_rx_byte_gather (
    .clk        (clk),
    .rst        (rst),
    .pkt_active (pkt_active),
    .ser_bit    (ser_bit),
    .ser_stuffed(ser_stuffed),
    .ser_err    (ser_err),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit slot: drive, wait CPB edges, check between and at the sampling edge
  task automatic slot(input logic b, input logic s, input logic e, input string req);
    bit quiet_ok = 1;
    bit exp_v = 0;
    ser_bit = b;
    ser_stuffed = s;
    ser_err = e;
    for (int i = 0; i < CPB; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i < CPB - 1) begin
        if (rx_valid || rx_data != m_last) quiet_ok = 0;
      end
    end
    chk(quiet_ok, "R3 strobe or bus change between slots", 0, 0);
    if (e) m_halt = 1;
    if (s) begin
      m_stuff++;
      if (m_stuff == WRAP) begin
        m_stuff = 0;
        m_drop = 1;
      end
    end else begin
      m_hold = {b, m_hold[W-1:1]};
      m_bits++;
      if (m_bits == W) begin
        m_bits = 0;
        if (!m_drop && !m_halt) exp_v = 1;
        m_drop = 0;
      end
    end
    chk(rx_valid == exp_v, req, int'(rx_valid), int'(exp_v));
    if (rx_valid) begin
      n_strobe++;
      t_prev = t_cur;
      t_cur = cyc;
    end
    if (exp_v) begin
      chk(rx_data == m_hold, req, int'(rx_data), int'(m_hold));
      m_last = m_hold;
    end
    ser_err = 1'b0;
  endtask

  task automatic send_byte(input logic [W-1:0] v, input logic [W-1:0] mask, input string req);
    for (int i = 0; i < W; i++) begin
      slot(v[i], 1'b0, 1'b0, req);
      if (mask[i]) slot(1'b0, 1'b1, 1'b0, req);
    end
  endtask

  task automatic end_pkt();
    pkt_active = 1'b0;
    ser_bit = 1'b0;
    ser_stuffed = 1'b0;
    ser_err = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(rx_valid == 1'b0, "R7 idle after packet end", int'(rx_valid), 0);
    m_bits = 0;
    m_stuff = 0;
    m_drop = 0;
    m_halt = 0;
    m_hold = '0;
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rx_valid == 1'b0 && rx_data == '0, "R1 reset state", int'(rx_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_valid == 1'b0 && rx_data == '0, "R1 after release", int'(rx_data), 0);

    // R2: bit order
    pkt_active = 1'b1;
    send_byte(8'h01, 8'h00, "R2 lsb first");
    chk(rx_data == 8'h01, "R2 first bit in bit 0", int'(rx_data), 8'h01);
    send_byte(8'h80, 8'h00, "R2 lsb first");
    chk(rx_data == 8'h80, "R2 last bit in bit 7", int'(rx_data), 8'h80);
    end_pkt();

    // R4 / R5: byte periods
    pkt_active = 1'b1;
    send_byte(8'h3C, 8'h00, "R4 first slot timing");
    send_byte(8'hC3, 8'h00, "R4 nominal");
    chk(t_cur - t_prev == 8 * CPB, "R4 nominal byte period", t_cur - t_prev, 8 * CPB);
    send_byte(8'h5A, 8'h04, "R5 one stuffed");
    chk(t_cur - t_prev == 9 * CPB, "R5 one stuffed slot", t_cur - t_prev, 9 * CPB);
    send_byte(8'h69, 8'h12, "R5 two stuffed");
    chk(t_cur - t_prev == 10 * CPB, "R5 two stuffed slots", t_cur - t_prev, 10 * CPB);
    end_pkt();

    // R3: every byte value
    pkt_active = 1'b1;
    n_strobe = 0;
    for (int v = 0; v < 256; v++) send_byte(W'(v), 8'h00, "R3 byte sweep");
    chk(n_strobe == 256, "R3 strobe count", n_strobe, 256);
    end_pkt();

    // R6: wrap of stuffed count skips one byte
    pkt_active = 1'b1;
    n_strobe = 0;
    send_byte(8'hA1, 8'h25, "R6 wrap");
    send_byte(8'hB2, 8'h49, "R6 wrap");
    send_byte(8'hC3, 8'h11, "R6 wrap byte skipped");
    send_byte(8'hD4, 8'h00, "R6 after wrap");
    chk(n_strobe == 3, "R6 one byte skipped", n_strobe, 3);
    for (int i = 0; i < 64; i++)
      send_byte(W'(i * 73 + 5), W'((i * 37) & 8'h7F), "R6 stuffing sweep");
    end_pkt();

    // R7: partial byte and stuffed count cleared
    pkt_active = 1'b1;
    slot(1'b1, 1'b0, 1'b0, "R7 partial");
    slot(1'b1, 1'b0, 1'b0, "R7 partial");
    slot(1'b0, 1'b0, 1'b0, "R7 partial");
    end_pkt();
    pkt_active = 1'b1;
    n_strobe = 0;
    send_byte(8'hA5, 8'h00, "R7 fresh byte");
    chk(n_strobe == 1 && rx_data == 8'hA5, "R7 partial discarded", int'(rx_data), 8'hA5);
    end_pkt();
    pkt_active = 1'b1;
    send_byte(8'h0F, 8'h1F, "R7 stuffs");
    end_pkt();
    pkt_active = 1'b1;
    n_strobe = 0;
    send_byte(8'hF0, 8'h1F, "R7 stuff count cleared");
    chk(n_strobe == 1, "R7 stuff count cleared", n_strobe, 1);
    end_pkt();

    // R8: error halts the packet
    pkt_active = 1'b1;
    send_byte(8'h11, 8'h00, "R8 before error");
    n_strobe = 0;
    slot(1'b1, 1'b0, 1'b0, "R8");
    slot(1'b0, 1'b0, 1'b1, "R8 error slot");
    for (int i = 0; i < 6; i++) slot(1'b1, 1'b0, 1'b0, "R8 halted");
    send_byte(8'h22, 8'h00, "R8 halted");
    chk(n_strobe == 0, "R8 no strobe after error", n_strobe, 0);
    end_pkt();
    pkt_active = 1'b1;
    n_strobe = 0;
    send_byte(8'h33, 8'h00, "R8 recovery");
    chk(n_strobe == 1 && rx_data == 8'h33, "R8 next packet works", int'(rx_data), 8'h33);
    end_pkt();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule